// File: doc/BRIEF.md
# Level Interrupt Storm Throttle

This block sits beside an interrupt redirection table. It watches what happens each time an end-of-interrupt (EOI) reaches a level-triggered pin. Normally a pin that is still asserted and unmasked at EOI time is sent again at once. A handler that never clears its source would then loop forever on that pin. To catch this, the block keeps a per-pin count of back-to-back EOI-driven redeliveries.

When a pin's count reaches a threshold, the block does not send that pin again at once. It arms a single deferred service timer instead. When the timer expires, the block sweeps every level-triggered pin and strobes service for each one that is still pending and has no remote-pending acknowledgement outstanding. Actual delivery to processors is done elsewhere. The caller supplies the per-pin EOI match strobe and the pin state, and acts on the two strobe outputs.

The threshold and the delay are parameters. The delay is counted in clock cycles and stands for a hundredth of a second at the system clock. The default of 2,500,000 cycles assumes a 250 MHz clock.

Top module: `storm_throttle`

## Requirements
- R1: When `eoi_hit[i]` and `trig_level[i]` are both 1 and the pin is pending (`pend[i]`=1) and unmasked (`mask[i]`=0), and its count is below THRESH-1, the pin's count rises by one and `redeliver[i]` pulses high for exactly the next cycle.
- R2: When `eoi_hit[i]` and `trig_level[i]` are both 1 but the pin is masked or not pending, its count returns to zero and `redeliver[i]` stays low.
- R3: The EOI that would take a pin's count to THRESH does not pulse `redeliver[i]`. It returns the count to zero. If no deferral is armed, `defer_armed` goes high in the next cycle.
- R4: A deferral armed at clock edge E expires at edge E+DELAY_CYC. At that edge `defer_armed` falls, and `sweep_svc` pulses for one cycle with bit i set exactly when `trig_level[i]`=1, `pend[i]`=1 and `remote[i]`=0 in the cycle before that edge.
- R5: A threshold hit while a deferral is armed, including in its expiry cycle, neither restarts nor extends the timer. The hit still returns that pin's count to zero.
- R6: An EOI on a pin with `trig_level[i]`=0, and any cycle with `eoi_hit[i]`=0, leaves the pin's count unchanged and keeps `redeliver[i]` low.
- R7: While `rst_n` is low, all counts are zero, any armed deferral is cancelled, and `redeliver`, `sweep_svc` and `defer_armed` are all low.
- R8: Pins are counted independently. Several pins can take EOIs, redeliver and hit the threshold in the same cycle, and a same-cycle hit on any pin arms the single deferral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_hit | input | NPINS | Per pin: an EOI matched this pin's vector in this cycle |
| trig_level | input | NPINS | Per pin: 1 = level-triggered, 0 = edge-triggered |
| pend | input | NPINS | Per pin: request still pending |
| mask | input | NPINS | Per pin: pin masked |
| remote | input | NPINS | Per pin: remote-pending acknowledgement outstanding |
| redeliver | output | NPINS | One-cycle strobe: redeliver this pin now |
| sweep_svc | output | NPINS | One-cycle strobe from the deferred sweep: service this pin |
| defer_armed | output | 1 | A deferred sweep is scheduled |

## Verification
The bench builds the block with NPINS=4, THRESH=5 and DELAY_CYC=12. With these values a steady storm on one pin reaches the threshold every five EOIs, so a second hit lands inside the twelve-cycle deferral window. This exercises the no-restart rule and hits in the expiry cycle within a few dozen cycles. The short window also lets a long random phase arm and expire the sweep hundreds of times. During that phase the bench mixes masked, non-pending, edge-triggered and remote-pending pins, and applies a reset in the middle of a deferral.

// File: rtl/storm_throttle.sv
module storm_throttle #(
  parameter int NPINS     = 8,
  parameter int THRESH    = 10000,
  parameter int DELAY_CYC = 2500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] eoi_hit,
  input  logic [NPINS-1:0] trig_level,
  input  logic [NPINS-1:0] pend,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] remote,
  output logic [NPINS-1:0] redeliver,
  output logic [NPINS-1:0] sweep_svc,
  output logic             defer_armed
);
  localparam int CW = $clog2(THRESH + 1);
  localparam int TW = $clog2(DELAY_CYC + 1);

  logic [NPINS-1:0] go_now, storm;
  logic [TW-1:0]    tmr;
  wire              expire = defer_armed && (tmr == TW'(DELAY_CYC - 1));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CW-1:0] cnt;
    wire ask  = eoi_hit[i] & trig_level[i];
    wire live = pend[i] & ~mask[i];
    wire top  = (cnt == CW'(THRESH - 1));

    assign go_now[i] = ask & live & ~top;
    assign storm[i]  = ask & live & top;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   cnt <= '0;
      else if (ask) cnt <= go_now[i] ? cnt + CW'(1) : '0;

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(THRESH));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) redeliver <= '0;
    else        redeliver <= go_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      defer_armed <= 1'b0;
      tmr         <= '0;
      sweep_svc   <= '0;
    end else begin
      sweep_svc <= '0;
      if (expire) begin
        defer_armed <= 1'b0;
        sweep_svc   <= trig_level & pend & ~remote;
      end else if (defer_armed) begin
        tmr <= tmr + TW'(1);
      end else if (|storm) begin
        defer_armed <= 1'b1;
        tmr         <= '0;
      end
    end

  a_r1_redeliver_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (redeliver & ~$past(eoi_hit & trig_level & pend & ~mask)) == '0);

  a_r4_sweep_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_svc & ~$past(trig_level & pend & ~remote)) == '0);

  a_r4_sweep_ends_deferral: assert property (@(posedge clk) disable iff (!rst_n)
    (|sweep_svc) |-> (!defer_armed && $past(defer_armed)));

  a_r3_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(defer_armed) |-> $past(|(eoi_hit & trig_level & pend & ~mask)));

  a_r5_timer_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_armed && $past(defer_armed)) |-> (tmr == $past(tmr) + TW'(1)));
endmodule

// File: tb/storm_throttle_test.sv
module storm_throttle_test;
  localparam int N = 4, TH = 5, DL = 12;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] eoi_hit = 0, trig_level = 0, pend = 0, mask = 0, remote = 0;
  logic [N-1:0] redeliver, sweep_svc;
  logic defer_armed;

  storm_throttle #(.NPINS(N), .THRESH(TH), .DELAY_CYC(DL)) uut (
    .clk(clk), .rst_n(rst_n), .eoi_hit(eoi_hit), .trig_level(trig_level),
    .pend(pend), .mask(mask), .remote(remote), .redeliver(redeliver),
    .sweep_svc(sweep_svc), .defer_armed(defer_armed));

  always #2 clk = ~clk;

  int vec = 0, bad = 0;
  int cnt[N];
  bit m_armed;
  int m_tmr;
  logic [N-1:0] e_rd, e_sw;

  task automatic m_reset();
    foreach (cnt[i]) cnt[i] = 0;
    m_armed = 0; m_tmr = 0; e_rd = 0; e_sw = 0;
  endtask

  task automatic m_step();
    bit hit = 0;
    e_rd = 0; e_sw = 0;
    for (int i = 0; i < N; i++)
      if (eoi_hit[i] && trig_level[i]) begin
        if (pend[i] && !mask[i]) begin
          if (cnt[i] + 1 == TH) begin cnt[i] = 0; hit = 1; end
          else begin cnt[i]++; e_rd[i] = 1; end
        end else cnt[i] = 0;
      end
    if (m_armed) begin
      if (m_tmr == DL - 1) begin
        m_armed = 0;
        e_sw = trig_level & pend & ~remote;
      end else m_tmr++;
    end else if (hit) begin
      m_armed = 1; m_tmr = 0;
    end
  endtask

  task automatic compare(string tag);
    vec++;
    if (redeliver !== e_rd || sweep_svc !== e_sw || defer_armed !== m_armed) begin
      bad++;
      if (!rst_n)
        $display("FAIL R7 [%s] rd=%b sw=%b arm=%b expected rd=%b sw=%b arm=%b",
                 tag, redeliver, sweep_svc, defer_armed, e_rd, e_sw, m_armed);
      else if (redeliver !== e_rd)
        $display("FAIL R1 R2 R3 R6 R8 [%s] redeliver=%b expected %b", tag, redeliver, e_rd);
      else if (sweep_svc !== e_sw)
        $display("FAIL R4 R5 [%s] sweep_svc=%b expected %b", tag, sweep_svc, e_sw);
      else
        $display("FAIL R3 R5 [%s] defer_armed=%b expected %b", tag, defer_armed, m_armed);
    end
  endtask

  task automatic tick(string tag, bit r, logic [N-1:0] e, l, p, m, rm);
    @(negedge clk);
    compare(tag);
    rst_n = r; eoi_hit = e; trig_level = l; pend = p; mask = m; remote = rm;
    if (!r) m_reset(); else m_step();
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    for (int k = 0; k < 3; k++) tick("R7 reset", 0, '1, '1, '1, '0, '0);
    // R1 R3 R5: steady storm on pin0, pin1 EOIs without pending (R2), pin3 edge (R6)
    for (int k = 0; k < 40; k++) tick("storm", 1, 4'b1011, 4'b0111, 4'b1001, 4'b0000, 4'b0000);
    // R2: masked pin0 clears its count
    for (int k = 0; k < 3; k++) tick("masked", 1, 4'b0001, 4'b1111, 4'b0001, 4'b0001, 4'b0000);
    // R6: idle and edge cycles interleaved with level EOIs on pin2
    for (int k = 0; k < 30; k++)
      tick("edge", 1, 4'b0100, (k % 3 == 0) ? 4'b1011 : 4'b1111, 4'b0100, 4'b0000, 4'b0010);
    // R8: all pins storming together
    for (int k = 0; k < 30; k++) tick("all", 1, '1, '1, '1, '0, 4'b1010);
    // R7: reset in the middle of a deferral
    for (int k = 0; k < 7; k++) tick("all", 1, '1, '1, '1, '0, '0);
    for (int k = 0; k < 2; k++) tick("R7 mid reset", 0, '1, '1, '1, '0, '0);
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] e, l, p, m, rm;
      for (int i = 0; i < N; i++) begin
        e[i]  = ($urandom % 100) < 60;
        l[i]  = ($urandom % 100) < 85;
        p[i]  = ($urandom % 100) < 85;
        m[i]  = ($urandom % 100) < 8;
        rm[i] = ($urandom % 100) < 30;
      end
      tick("random", !(k == 1500 || k == 1501), e, l, p, m, rm);
    end
    @(negedge clk);
    compare("final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule